// File: doc/BRIEF.md
# Sidetone IIR Coefficient Access Port

This block stores the full coefficient set of one multi-band sidetone IIR filter. A host reaches that storage through a small register window: a pointer register picks a byte position inside coefficient space, and a data register reads or writes the byte at that position. The block also holds a per-band enable register and offers a parallel read port. Through that port the filter datapath fetches any assembled coefficient by band and tap index.

Coefficient space holds 5 bands with 5 taps each. Each coefficient spans 4 consecutive byte positions, least significant byte first. The linear byte position is `(band * 5 + tap) * 4 + lane`. The most significant lane carries only 6 valid bits, so each coefficient is 30 bits wide.

Writes through the data register advance the pointer. Reads leave it where it is, so a host that reads a coefficient back writes the pointer again before each byte. Several filter instances sit at register offsets 16 apart, and the block takes its window offset as a parameter.

Top module: `iir_coef_port`

## Requirements
- R1: Synchronous active-high reset clears the pointer, every stored coefficient and every band enable.
- R2: The pointer register is at window offset 0. A write keeps bits 6:0. Bit 7 is ignored and reads back as 0.
- R3: Each write to the data register (window offset 1) stores its byte at the current pointer and then adds one to the pointer. The pointer wraps from 127 to 0.
- R4: A read of the data register returns the byte at the current pointer and leaves the pointer unchanged.
- R5: Byte position `(band*5+tap)*4 + lane` holds bits `8*lane+7 : 8*lane` of the coefficient for that band and tap.
- R6: In lane 3 only bits 5:0 are stored. Bits 7:6 of a write are dropped and read back as 0.
- R7: Positions 100 to 127 have no storage. Writes there change no coefficient but still advance the pointer, and reads there return 0.
- R8: The band-enable register is at window offset 2. Bit b (0..4) enables band b. Bits 7:5 are ignored and read as 0. Its value appears on `band_en`.
- R9: `dp_coef` is a combinational function of `dp_band` and `dp_tap`. It returns the 30-bit coefficient, or 0 for a band or tap index of 5 or more. A host write becomes visible there right after the clock edge that takes it.
- R10: Accesses to any index other than `REG_BASE+0..2` change no state, and reads there return 0. Reads have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_idx | input | 8 | Register index on the host bus |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational while a read is presented |
| band_en | output | 5 | Per-band enable bits |
| dp_band | input | 3 | Datapath band select |
| dp_tap | input | 3 | Datapath tap select |
| dp_coef | output | 30 | Assembled coefficient for the selected band and tap |

## Verification
The hardest part to reach from the ports is the unbacked region at positions 100 to 127 together with the wrap from 127 to 0. Only a long run of data writes walks the pointer through that region and back. The stimulus therefore streams 128 bytes from position 0 in one run. It confirms that the pointer lands back at 0, and then reads every position, checking the dropped lane-3 bits and the zero region. A separate check pins the cycle in which a host write appears on the datapath port: the port is sampled just before and just after the clock edge that takes the write.

// File: rtl/iir_coef_pkg.sv
package iir_coef_pkg;

    localparam int LANES      = 4;
    localparam int PTR_W      = 7;
    localparam int DEF_BANDS  = 5;
    localparam int DEF_TAPS   = 5;
    localparam int DEF_COEF_W = 30;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_BAND = 2'd2,
        SEL_NONE = 2'd3
    } win_sel_e;

    // number of stored bits in byte lane l of a coefficient of width cw
    function automatic int lane_bits(input int l, input int cw);
        int rest;
        rest = cw - 8 * l;
        if (rest >= 8) return 8;
        if (rest <= 0) return 0;
        return rest;
    endfunction

endpackage

// File: rtl/iir_win_decode.sv
module iir_win_decode
    import iir_coef_pkg::*;
#(
    parameter logic [7:0] REG_BASE = 8'h10
) (
    input  logic       host_en,
    input  logic       host_we,
    input  logic [7:0] host_idx,
    output win_sel_e   win_sel,
    output logic       ptr_load,
    output logic       data_wr,
    output logic       band_wr
);

    logic [7:0] rel_idx;

    assign rel_idx = host_idx - REG_BASE;

    always_comb begin
        win_sel = SEL_NONE;
        if (host_en) begin
            case (rel_idx)
                8'd0:    win_sel = SEL_PTR;
                8'd1:    win_sel = SEL_DATA;
                8'd2:    win_sel = SEL_BAND;
                default: win_sel = SEL_NONE;
            endcase
        end
    end

    assign ptr_load = host_we && (win_sel == SEL_PTR);
    assign data_wr  = host_we && (win_sel == SEL_DATA);
    assign band_wr  = host_we && (win_sel == SEL_BAND);

endmodule

// File: rtl/iir_ptr_reg.sv
module iir_ptr_reg #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          bump,
    output logic [PW-1:0] ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (bump) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // R3
    ptr_bump_chk: assert property (@(posedge clk) disable iff (rst)
        (bump && !load) |=> ptr_q == $past(ptr_q) + PW'(1));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bump && !load) |=> $stable(ptr_q));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr_q == $past(load_val));

endmodule

// File: rtl/iir_band_en.sv
module iir_band_en #(
    parameter int BANDS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [BANDS-1:0] wdata,
    output logic [BANDS-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr) begin
            en_q <= wdata;
        end
    end

    // R8
    band_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> en_q == $past(wdata));

    // R8
    band_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(en_q));

endmodule

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
    import iir_coef_pkg::*;
#(
    parameter int WORDS  = 25,
    parameter int COEF_W = 30,
    parameter int PW     = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PW-1:0]              ptr,
    input  logic [7:0]                 wr_byte,
    output logic [7:0]                 rd_byte,
    input  logic [$clog2(WORDS)-1:0]   dp_word,
    input  logic                       dp_ok,
    output logic [COEF_W-1:0]          dp_coef
);

    localparam int BYTES  = WORDS * LANES;
    localparam int LANE_W = $clog2(LANES);
    localparam int WSEL_W = PW - LANE_W;
    localparam int PAD_W  = 8 * LANES - COEF_W;

    logic [WORDS*COEF_W-1:0] coef_flat;
    logic                    in_range;
    logic [LANE_W-1:0]       ptr_lane;
    logic [WSEL_W-1:0]       ptr_word;
    logic [WSEL_W-1:0]       rd_word;
    logic [COEF_W-1:0]       rd_coef;
    logic [8*LANES-1:0]      rd_pad;

    assign in_range = ptr < PW'(BYTES);
    assign ptr_lane = ptr[LANE_W-1:0];
    assign ptr_word = ptr[PW-1:LANE_W];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int LB = lane_bits(l, COEF_W);
            if (LB > 0) begin : g_store
                logic [LB-1:0] lane_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        lane_q <= '0;
                    end else if (wr_en && in_range &&
                                 ptr_word == WSEL_W'(w) &&
                                 ptr_lane == LANE_W'(l)) begin
                        lane_q <= wr_byte[LB-1:0];
                    end
                end
                assign coef_flat[w*COEF_W + 8*l +: LB] = lane_q;
            end
        end
    end

    assign rd_word = in_range ? ptr_word : '0;
    assign rd_coef = coef_flat[int'(rd_word)*COEF_W +: COEF_W];
    assign rd_pad  = {{PAD_W{1'b0}}, rd_coef};
    assign rd_byte = in_range ? rd_pad[8*ptr_lane +: 8] : 8'h00;

    assign dp_coef = dp_ok ? coef_flat[int'(dp_word)*COEF_W +: COEF_W] : '0;

endmodule

// File: rtl/iir_coef_port.sv
module iir_coef_port
    import iir_coef_pkg::*;
#(
    parameter logic [7:0] REG_BASE = 8'h10,
    parameter int BANDS  = DEF_BANDS,
    parameter int TAPS   = DEF_TAPS,
    parameter int COEF_W = DEF_COEF_W,
    localparam int BSEL_W = $clog2(BANDS),
    localparam int TSEL_W = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [7:0]        host_idx,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [BANDS-1:0]  band_en,
    input  logic [BSEL_W-1:0] dp_band,
    input  logic [TSEL_W-1:0] dp_tap,
    output logic [COEF_W-1:0] dp_coef
);

    localparam int WORDS    = BANDS * TAPS;
    localparam int WORD_W   = $clog2(WORDS);
    localparam int BYTES    = WORDS * LANES;
    localparam int LANE_W   = $clog2(LANES);
    localparam int TOP_BITS = lane_bits(LANES - 1, COEF_W);
    localparam logic [7:0] TOP_MASK = 8'((1 << TOP_BITS) - 1);

    win_sel_e           win_sel;
    logic               ptr_load;
    logic               data_wr;
    logic               band_wr;
    logic [PTR_W-1:0]   ptr_q;
    logic [7:0]         bank_byte;
    logic [WORD_W-1:0]  dp_word;
    logic               dp_ok;
    logic               host_rd;

    iir_win_decode #(.REG_BASE(REG_BASE)) u_dec (
        .host_en  (host_en),
        .host_we  (host_we),
        .host_idx (host_idx),
        .win_sel  (win_sel),
        .ptr_load (ptr_load),
        .data_wr  (data_wr),
        .band_wr  (band_wr)
    );

    iir_ptr_reg #(.PW(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (host_wdata[PTR_W-1:0]),
        .bump     (data_wr),
        .ptr_q    (ptr_q)
    );

    iir_band_en #(.BANDS(BANDS)) u_band (
        .clk   (clk),
        .rst   (rst),
        .wr    (band_wr),
        .wdata (host_wdata[BANDS-1:0]),
        .en_q  (band_en)
    );

    always_comb begin
        dp_ok   = (int'(dp_band) < BANDS) && (int'(dp_tap) < TAPS);
        dp_word = WORD_W'(int'(dp_band) * TAPS + int'(dp_tap));
    end

    iir_coef_bank #(.WORDS(WORDS), .COEF_W(COEF_W), .PW(PTR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .ptr     (ptr_q),
        .wr_byte (host_wdata),
        .rd_byte (bank_byte),
        .dp_word (dp_word),
        .dp_ok   (dp_ok),
        .dp_coef (dp_coef)
    );

    assign host_rd = host_en && !host_we;

    always_comb begin
        host_rdata = 8'h00;
        if (host_rd) begin
            case (win_sel)
                SEL_PTR:  host_rdata = 8'(ptr_q);
                SEL_DATA: host_rdata = bank_byte;
                SEL_BAND: host_rdata = 8'(band_en);
                default:  host_rdata = 8'h00;
            endcase
        end
    end

    // checker state for the datapath follow property
    logic              hit_d1;
    logic [LANE_W-1:0] lane_d1;
    logic [7:0]        exp_d1;
    logic [BSEL_W-1:0] band_d1;
    logic [TSEL_W-1:0] tap_d1;
    logic [8*LANES-1:0] dp_pad;
    logic [7:0]        dp_lane_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_d1  <= 1'b0;
            lane_d1 <= '0;
            exp_d1  <= '0;
            band_d1 <= '0;
            tap_d1  <= '0;
        end else begin
            hit_d1  <= data_wr && dp_ok && (ptr_q < PTR_W'(BYTES)) &&
                       (ptr_q[PTR_W-1:LANE_W] == (PTR_W-LANE_W)'(dp_word));
            lane_d1 <= ptr_q[LANE_W-1:0];
            exp_d1  <= (ptr_q[LANE_W-1:0] == LANE_W'(LANES - 1)) ?
                       (host_wdata & TOP_MASK) : host_wdata;
            band_d1 <= dp_band;
            tap_d1  <= dp_tap;
        end
    end

    assign dp_pad       = {{(8*LANES-COEF_W){1'b0}}, dp_coef};
    assign dp_lane_byte = dp_pad[8*lane_d1 +: 8];

    // R9
    dp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_d1 && dp_band == band_d1 && dp_tap == tap_d1) |-> dp_lane_byte == exp_d1);

    // R7
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && win_sel == SEL_DATA && ptr_q >= PTR_W'(BYTES)) |-> host_rdata == 8'h00);

    // R6
    top_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && win_sel == SEL_DATA && ptr_q[LANE_W-1:0] == LANE_W'(LANES - 1))
        |-> (host_rdata & ~TOP_MASK) == 8'h00);

    // R10
    stray_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (host_en && win_sel == SEL_NONE) |=> ($stable(ptr_q) && $stable(band_en)));

endmodule

// File: tb/iir_coef_port_tb.sv
`timescale 1ns/1ps
module iir_coef_port_tb_top;

    localparam logic [7:0] BASE = 8'h10;
    localparam logic [7:0] I_PTR  = BASE;
    localparam logic [7:0] I_DATA = BASE + 8'd1;
    localparam logic [7:0] I_BAND = BASE + 8'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_idx = 8'h00;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [4:0]  band_en;
    logic [2:0]  dp_band = 3'd0;
    logic [2:0]  dp_tap = 3'd0;
    logic [29:0] dp_coef;

    int n_chk = 0;
    int n_err = 0;
    int model_mem [128];
    int model_ptr = 0;

    always #10 clk = ~clk;

    iir_coef_port #(.REG_BASE(BASE)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .band_en    (band_en),
        .dp_band    (dp_band),
        .dp_tap     (dp_tap),
        .dp_coef    (dp_coef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // model of a data-register write (R3, R6, R7)
    function automatic void model_data_wr(input int d);
        if (model_ptr < 100)
            model_mem[model_ptr] = ((model_ptr % 4) == 3) ? (d & 8'h3F) : (d & 8'hFF);
        model_ptr = (model_ptr + 1) % 128;
    endfunction

    function automatic logic [29:0] model_coef(input int b, input int t);
        logic [31:0] v;
        int base;
        if (b >= 5 || t >= 5) return 30'd0;
        base = (b * 5 + t) * 4;
        v = 32'(model_mem[base]) | (32'(model_mem[base+1]) << 8) |
            (32'(model_mem[base+2]) << 16) | (32'(model_mem[base+3]) << 24);
        return v[29:0];
    endfunction

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_idx = idx; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [7:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_idx = idx;
        #2;
        d = host_rdata;
        @(negedge clk);
        host_en = 1'b0;
    endtask

    task automatic dp_sweep(input string req);
        for (int b = 0; b < 8; b++) begin
            for (int t = 0; t < 8; t++) begin
                if ((b < 5 && t < 5) || (b == 5 && t == 0) || (b == 7 && t == 7) || (b == 0 && t == 6)) begin
                    @(negedge clk);
                    dp_band = 3'(b); dp_tap = 3'(t);
                    #2;
                    chk(req, 32'(dp_coef), 32'(model_coef(b, t)));
                end
            end
        end
    endtask

    task automatic stream_fill(input int kind);
        wr(I_PTR, 8'h00);
        model_ptr = 0;
        for (int i = 0; i < 128; i++) begin
            int d;
            d = (kind == 0) ? ((i * 37 + 11) & 255) : ((255 - i * 5) & 255);
            wr(I_DATA, 8'(d));
            model_data_wr(d);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        for (int i = 0; i < 128; i++) model_mem[i] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(I_PTR, v);  chk("R1 pointer after reset", 32'(v), 32'h0);
        rd(I_BAND, v); chk("R1 band enable readback after reset", 32'(v), 32'h0);
        chk("R1 band_en port after reset", 32'(band_en), 32'h0);
        dp_sweep("R1 coefficient after reset");

        // R2: pointer write, bit 7 dropped
        wr(I_PTR, 8'hFF); rd(I_PTR, v); chk("R2 pointer bit7 ignored", 32'(v), 32'h7F);
        wr(I_PTR, 8'h85); rd(I_PTR, v); chk("R2 pointer load", 32'(v), 32'h05);

        // R3: two data writes advance the pointer by two
        wr(I_PTR, 8'h03); model_ptr = 3;
        wr(I_DATA, 8'h12); model_data_wr(8'h12);
        wr(I_DATA, 8'h34); model_data_wr(8'h34);
        rd(I_PTR, v); chk("R3 pointer advance", 32'(v), 32'h05);

        // R3, R7: full stream through the hole and wrap
        stream_fill(0);
        rd(I_PTR, v); chk("R3 pointer wrap 127 to 0", 32'(v), 32'h00);

        // R4, R5, R6, R7: read back every position
        for (int a = 0; a < 128; a++) begin
            wr(I_PTR, 8'(a));
            rd(I_DATA, v);
            rd(I_DATA, v2);
            if (a >= 100)      chk("R7 unbacked position reads zero", 32'(v), 32'h0);
            else if (a % 4 == 3) chk("R6 lane3 masked readback", 32'(v), 32'(model_mem[a]));
            else               chk("R5 byte readback", 32'(v), 32'(model_mem[a]));
            chk("R4 repeated read same byte", 32'(v2), 32'(v));
            rd(I_PTR, v);
            chk("R4 pointer unchanged by read", 32'(v), 32'(a));
        end

        // R5, R9: assembled coefficients on the datapath port
        dp_sweep("R5 assembled coefficient");

        // second pattern overwrites everything
        stream_fill(1);
        dp_sweep("R9 coefficient after overwrite");

        // R9: cycle of visibility on the datapath port
        wr(I_PTR, 8'd53); model_ptr = 53;
        @(negedge clk);
        dp_band = 3'd2; dp_tap = 3'd3;
        host_en = 1'b1; host_we = 1'b1; host_idx = I_DATA; host_wdata = 8'hA5;
        #2;
        chk("R9 old value before edge", 32'(dp_coef), 32'(model_coef(2, 3)));
        model_data_wr(8'hA5);
        @(posedge clk);
        #2;
        chk("R9 new value after edge", 32'(dp_coef), 32'(model_coef(2, 3)));
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;

        // R6: lane-3 write through datapath
        wr(I_PTR, 8'd55); model_ptr = 55;
        wr(I_DATA, 8'hFF); model_data_wr(8'hFF);
        @(negedge clk); #2;
        chk("R6 lane3 top bits dropped", 32'(dp_coef), 32'(model_coef(2, 3)));

        // R8: band enables
        wr(I_BAND, 8'hFF); rd(I_BAND, v);
        chk("R8 band readback masked", 32'(v), 32'h1F);
        chk("R8 band_en port", 32'(band_en), 32'h1F);
        wr(I_BAND, 8'h0A); rd(I_BAND, v);
        chk("R8 band readback pattern", 32'(v), 32'h0A);
        chk("R8 band_en port pattern", 32'(band_en), 32'h0A);

        // R10: stray indices change nothing
        wr(I_PTR, 8'd20); model_ptr = 20;
        wr(BASE + 8'd3, 8'h55);
        wr(BASE - 8'd1, 8'h33);
        wr(BASE + 8'd17, 8'h77);
        rd(I_PTR, v);  chk("R10 pointer unchanged by stray write", 32'(v), 32'd20);
        rd(I_BAND, v); chk("R10 band unchanged by stray write", 32'(v), 32'h0A);
        rd(I_DATA, v); chk("R10 byte unchanged by stray write", 32'(v), 32'(model_mem[20]));
        rd(BASE + 8'd3, v); chk("R10 stray index reads zero", 32'(v), 32'h0);
        dp_sweep("R10 coefficients unchanged");

        summary();
        $finish;
    end

endmodule